// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of a receive path and rules on each incoming Ethernet frame from its destination address alone. The six address bytes arrive one per cycle on `in_byte` while `in_valid` is high, and the first byte also carries `in_start`. Idle cycles between bytes are allowed. While the bytes stream in, the filter does three things: it compares them against the station address, it notes whether the group bit is set, and it folds them into a CRC-32 register. One cycle after the sixth byte it raises `dec_valid` for a single cycle, with `dec_accept` giving the verdict.

Unicast frames pass only on an exact station-address match. Group frames pass when one of the pass-all-group controls is set. Otherwise they pass when the 64-bit hash table has a one at the position selected by the CRC. The broadcast address is treated as an ordinary group address, so it passes only when its hash bit is set. A four-bit receive control input gates the whole decision, and can also force every frame through.

The sequencing lives in a three-state machine:
- `ST_IDLE` waits for a first byte (transition *open*: `in_valid & in_start` → `ST_ADDR`).
- `ST_ADDR` collects bytes 2 to 6. Transition *restart*: a new first byte stays in `ST_ADDR` and discards the partial address. Transition *complete*: the sixth byte → `ST_DONE`.
- `ST_DONE` presents the verdict for one cycle. Transition *chain*: a new first byte → `ST_ADDR`. Transition *release*: otherwise → `ST_IDLE`.

Top module: `rx_addr_filter`

## Requirements
- R1: An address begins with a byte that has `in_valid` and `in_start` both high. Bytes with `in_valid` high and `in_start` low are taken only while an address is open, and cycles with `in_valid` low are skipped at any point. The first byte received is address byte 0.
- R2: `dec_valid` is high exactly in the cycle after the edge that takes the sixth address byte, and it lasts one cycle. `dec_accept` is never high while `dec_valid` is low.
- R3: A byte with `in_valid` and `in_start` high that arrives while an address is partly received discards the partial address and becomes byte 0 of a new one.
- R4: When `rx_ctrl[0]` (receive on) is 0, every frame is rejected, whatever the other control bits, the addresses and the table hold.
- R5: With `rx_ctrl[0]`=1 and `rx_ctrl[1]` (accept any) = 1, every frame is accepted.
- R6: A frame whose byte 0 has bit 0 clear is unicast. It is accepted, when receive is on and accept-any is off, only if address byte k equals `station_addr[8k+7:8k]` for every k from 0 to 5.
- R7: A frame whose byte 0 has bit 0 set is a group frame. The CRC register is preset to all ones and then runs through the six bytes, least significant bit first, with polynomial 0x04C11DB7 shifted in from the top. The index is bits 31:26 of the uncomplemented register. The upper three index bits select table byte `hash_table[8b+7:8b]`, and the lower three select the bit within that byte. The group frame is accepted iff that bit is 1, unless R4, R5 or R9 decide first.
- R8: The all-ones broadcast address is accepted only through bit 7 of table byte 7 (`hash_table[63]`). There is no other broadcast path.
- R9: With receive on and accept-any off, setting `rx_ctrl[2]` or `rx_ctrl[3]` accepts every group frame regardless of the table, and leaves unicast handling unchanged.
- R10: While `rst_n` is low, and after reset until the first full address, `dec_valid` and `dec_accept` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_ctrl | input | 4 | Receive control: bit 0 on, bit 1 accept any, bits 2 and 3 pass all group frames |
| station_addr | input | 48 | Station address, byte k at bits 8k+7:8k |
| hash_table | input | 64 | Group hash table, byte b at bits 8b+7:8b |
| in_valid | input | 1 | Address byte present on `in_byte` |
| in_start | input | 1 | Marks byte 0 of an address (qualified by `in_valid`) |
| in_byte | input | 8 | Address byte |
| dec_valid | output | 1 | One-cycle strobe: verdict present |
| dec_accept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
Three kinds of internal fault show up at the ports, and the bench watches each in the cycle of the verdict. A byte counter that drifts moves or suppresses `dec_valid`, and the bench samples at the first cycle after the sixth byte and demands the strobe there. A corrupted CRC register or a misordered CRC step lands on the wrong table bit. Sweeping all 64 hash indices, with one-hot and inverted tables, turns that into a wrong verdict on the same frame. A broken match accumulator or a stale group flag shows up as a wrong verdict within one frame, through single-bit flips of every station byte and the restart cases.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int unsigned CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

    localparam int unsigned CTL_ON    = 0;
    localparam int unsigned CTL_ANY   = 1;
    localparam int unsigned CTL_GRP_A = 2;
    localparam int unsigned CTL_GRP_B = 3;
    localparam int unsigned CTL_W     = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DONE = 2'd2
    } rxf_state_e;
endpackage

// File: rtl/rxf_crc_byte.sv
module rxf_crc_byte
    import rxf_pkg::*;
#(
    parameter logic [31:0] POLY = CRC_POLY
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       data,
    output logic [CRC_W-1:0] crc_out
);
    logic [CRC_W-1:0] chain [0:8];

    assign chain[0] = crc_in;

    // One bit per stage, least significant data bit first.
    for (genvar b = 0; b < 8; b++) begin : g_bit
        logic fb;
        assign fb           = chain[b][CRC_W-1] ^ data[b];
        assign chain[b+1]   = {chain[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_out = chain[8];
endmodule

// File: rtl/rxf_hash_pick.sv
module rxf_hash_pick #(
    parameter int unsigned HASH_BITS = 64,
    localparam int unsigned IDX_W    = $clog2(HASH_BITS)
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic [HASH_BITS-1:0] table_bits,
    output logic                 hit
);
    // Byte = idx >> 3, bit = idx % 8; flat position is byte*8 + bit = idx.
    assign hit = table_bits[idx];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned HASH_BYTES = 8,
    localparam int unsigned ADDR_W    = ADDR_BYTES * 8,
    localparam int unsigned HASH_BITS = HASH_BYTES * 8,
    localparam int unsigned IDX_W     = $clog2(HASH_BITS),
    localparam int unsigned CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CTL_W-1:0]     rx_ctrl,
    input  logic [ADDR_W-1:0]    station_addr,
    input  logic [HASH_BITS-1:0] hash_table,
    input  logic                 in_valid,
    input  logic                 in_start,
    input  logic [7:0]           in_byte,
    output logic                 dec_valid,
    output logic                 dec_accept
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    rxf_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CRC_W-1:0] crc_q, crc_src, crc_nxt;
    logic             match_q, grp_q;
    logic             first, byte_eq, hash_hit, verdict;
    logic [7:0]       stn_b [ADDR_BYTES];
    logic [7:0]       cmp_byte;

    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_stn
        assign stn_b[k] = station_addr[8*k +: 8];
    end

    assign first    = in_valid & in_start;
    assign crc_src  = first ? '1 : crc_q;
    assign cmp_byte = first ? stn_b[0] : stn_b[cnt_q];
    assign byte_eq  = (in_byte == cmp_byte);

    rxf_crc_byte u_crc (
        .crc_in  (crc_src),
        .data    (in_byte),
        .crc_out (crc_nxt)
    );

    rxf_hash_pick #(.HASH_BITS(HASH_BITS)) u_pick (
        .idx        (crc_q[CRC_W-1 -: IDX_W]),
        .table_bits (hash_table),
        .hit        (hash_hit)
    );

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (first) state_d = ST_ADDR;
            ST_ADDR: begin
                if (first)                              state_d = ST_ADDR;
                else if (in_valid && cnt_q == LAST_IDX) state_d = ST_DONE;
            end
            ST_DONE: state_d = first ? ST_ADDR : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and address datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            crc_q   <= '1;
            match_q <= 1'b0;
            grp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (first) begin
                crc_q   <= crc_nxt;
                match_q <= byte_eq;
                grp_q   <= in_byte[0];
                cnt_q   <= CNT_W'(1);
            end else if (state_q == ST_ADDR && in_valid) begin
                crc_q   <= crc_nxt;
                match_q <= match_q & byte_eq;
                cnt_q   <= cnt_q + CNT_W'(1);
            end
        end
    end

    // Verdict, in priority order: off, accept any, group, unicast.
    always_comb begin
        if (!rx_ctrl[CTL_ON])       verdict = 1'b0;
        else if (rx_ctrl[CTL_ANY])  verdict = 1'b1;
        else if (grp_q)             verdict = rx_ctrl[CTL_GRP_A] | rx_ctrl[CTL_GRP_B] | hash_hit;
        else                        verdict = match_q;
    end

    // Outputs.
    always_comb begin
        dec_valid  = 1'b0;
        dec_accept = 1'b0;
        unique case (state_q)
            ST_DONE: begin
                dec_valid  = 1'b1;
                dec_accept = verdict;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
    import rxf_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    localparam int unsigned CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CTL_W-1:0] rx_ctrl,
    input logic             in_valid,
    input logic             in_start,
    input logic             in_byte0,
    input logic             dec_valid,
    input logic             dec_accept
);
    logic [CNT_W-1:0] seen_q;
    logic             grp_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q     <= '0;
            grp_seen_q <= 1'b0;
        end else if (in_valid && in_start) begin
            seen_q     <= CNT_W'(1);
            grp_seen_q <= in_byte0;
        end else if (seen_q == CNT_W'(ADDR_BYTES)) begin
            seen_q <= '0;
        end else if (seen_q != '0 && in_valid) begin
            seen_q <= seen_q + CNT_W'(1);
        end
    end

    p_strobe_after_sixth_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == CNT_W'(ADDR_BYTES - 1) && in_valid && !in_start) |=> dec_valid);

    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    p_accept_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);

    p_strobe_needs_full_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> seen_q == CNT_W'(ADDR_BYTES));

    p_off_rejects_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !rx_ctrl[CTL_ON]) |-> !dec_accept);

    p_any_accepts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && rx_ctrl[CTL_ON] && rx_ctrl[CTL_ANY]) |-> dec_accept);

    p_group_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && rx_ctrl[CTL_ON] && grp_seen_q &&
         (rx_ctrl[CTL_GRP_A] || rx_ctrl[CTL_GRP_B])) |-> dec_accept);
endmodule

bind rx_addr_filter rxf_checker #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_ctrl    (rx_ctrl),
    .in_valid   (in_valid),
    .in_start   (in_start),
    .in_byte0   (in_byte[0]),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept)
);

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rx_ctrl;
    logic [47:0] station_addr;
    logic [63:0] hash_table;
    logic        in_valid, in_start;
    logic [7:0]  in_byte;
    logic        dec_valid, dec_accept;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    rx_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .rx_ctrl(rx_ctrl), .station_addr(station_addr),
        .hash_table(hash_table), .in_valid(in_valid), .in_start(in_start),
        .in_byte(in_byte), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic report();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    function automatic logic [31:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Hash index per R7.
    function automatic logic [5:0] hash_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = c[31] ^ a[i];
            c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
        end
        return c[31:26];
    endfunction

    function automatic logic expect_accept(input logic [3:0] ctl, input logic [47:0] a,
                                           input logic [47:0] stn, input logic [63:0] tbl);
        if (!ctl[0]) return 1'b0;                     // R4
        if (ctl[1])  return 1'b1;                     // R5
        if (a[0])    return ctl[2] | ctl[3] | tbl[hash_idx(a)]; // R9, R7
        return a == stn;                              // R6
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Send six bytes; gap inserts idle cycles. Returns sampled verdict.
    task automatic send(input logic [47:0] a, input int gap, output logic v, output logic acc);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (dec_valid !== 1'b0) begin
                checks++; fails++;
                $display("FAIL R2: actual=%0b expected=0 (strobe during bytes)", dec_valid);
            end
            in_valid = 1'b1;
            in_start = (i == 0);
            in_byte  = a[8*i +: 8];
            if (gap > 0 && i < 5) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0; in_start = 1'b0; in_byte = 8'hA5;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0;
        v = dec_valid; acc = dec_accept;
        @(negedge clk);
    endtask

    task automatic frame_check(input logic [47:0] a, input int gap, input string req);
        logic v, acc;
        send(a, gap, v, acc);
        check(v, 1'b1, req);
        check(acc, expect_accept(rx_ctrl, a, station_addr, hash_table), req);
    endtask

    initial begin
        logic v, acc;
        logic [47:0] a;
        rst_n = 1'b0; rx_ctrl = 4'h1; station_addr = 48'h5A4433221100;
        hash_table = '0; in_valid = 1'b0; in_start = 1'b0; in_byte = '0;
        repeat (3) @(negedge clk);
        check(dec_valid, 1'b0, "R10 valid in reset");
        check(dec_accept, 1'b0, "R10 accept in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(dec_valid, 1'b0, "R10 after reset");

        // R1: bytes without start are ignored while idle.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); in_valid = 1'b1; in_start = 1'b0; in_byte = 8'h11;
        end
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check(dec_valid, 1'b0, "R1 stray bytes");

        // R6 unicast exact match, with and without gaps (R1).
        frame_check(station_addr, 0, "R6 match");
        frame_check(station_addr, 2, "R1 gaps match");
        for (int p = 0; p < 6; p++)
            for (int b = 0; b < 8; b++)
                frame_check(station_addr ^ (48'h1 << (8*p + b)), 0, "R6 flip");

        // R7 exhaustive over hash indices.
        rx_ctrl = 4'h1;
        for (int k = 0; k < 64; k++) begin
            a = {next_rand()[15:0], next_rand()} | 48'h1;
            while (hash_idx(a) != 6'(k)) a = {next_rand()[15:0], next_rand()} | 48'h1;
            hash_table = 64'h1 << k;
            frame_check(a, 0, "R7 onehot");
            hash_table = ~(64'h1 << k);
            frame_check(a, k % 3, "R7 inverted");
        end

        // R8 broadcast only via bit 63.
        hash_table = 64'h1 << 63;
        send(48'hFFFF_FFFF_FFFF, 0, v, acc);
        check(acc, 1'b1, "R8 bit63 set");
        hash_table = ~(64'h1 << 63);
        send(48'hFFFF_FFFF_FFFF, 0, v, acc);
        check(acc, 1'b0, "R8 bit63 clear");

        // R4, R5, R9: all control values over four frame kinds.
        a = {next_rand()[15:0], next_rand()} | 48'h1;
        hash_table = 64'h1 << hash_idx(a);
        for (int c = 0; c < 16; c++) begin
            logic [47:0] miss;
            rx_ctrl = 4'(c);
            miss = {next_rand()[15:0], next_rand()} | 48'h1;
            while (hash_idx(miss) == hash_idx(a)) miss = {next_rand()[15:0], next_rand()} | 48'h1;
            frame_check(station_addr, 0, "R4/R5 unicast hit");
            frame_check(station_addr ^ 48'h0100, 0, "R4 R5 R9 unicast miss");
            frame_check(a, 0, "R9 group hit");
            frame_check(miss, 0, "R9 group miss");
        end

        // R3: restart mid-address.
        rx_ctrl = 4'h1; hash_table = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); in_valid = 1'b1; in_start = (i == 0); in_byte = 8'hFF;
        end
        frame_check(station_addr, 0, "R3 restart to match");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); in_valid = 1'b1; in_start = (i == 0); in_byte = station_addr[8*i +: 8];
        end
        frame_check(station_addr ^ 48'h80_0000_0000, 0, "R3 restart to miss");

        done = 1'b1;
        report();
    end
endmodule